// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a register-programmed SPI master that moves short bursts of bytes through a sixteen-entry queue. Software fills a transmit file and a per-entry command file through a simple 32-bit word register port, sets a first and a last queue index, and then sets the run bit. The engine walks the queue from the first index to the last, shifts each byte out most-significant bit first in SPI mode 0, and captures the byte returned on the input line into a receive file. At the end of the walk it clears the run bit and raises a completion flag.

Each command entry picks one of the chip-select lines and says whether that select stays active after its byte. A hold option and a lock register together keep the select asserted after a queue run, so one device transaction can span several runs. The pins belong either to this master or to a separate boot-read engine, chosen by a mode register. The hand-over to the master is refused while the boot engine reports that it is busy.

Register word map (7-bit word address): transmit file 0x00-0x1F (byte i at 2*i), receive file 0x20-0x3F (byte i at 0x20+2*i+1), command file 0x40-0x4F, first index 0x50, last index 0x51, control 0x52, status 0x53, lock 0x54, divider 0x55, pin mode 0x56.

Top module: `qmspi_ctrl`

## Requirements
- R1: After reset, the pin mode, control, status, lock and divider registers read 0. All chip-select outputs are high, SCK and MOSI are low, and pins_master is 0.
- R2: The transmit byte for queue entry i is written at word 2*i (bits 7:0) and appears on MOSI most-significant bit first. MOSI is stable on each rising SCK edge, and SCK idles low.
- R3: The byte sampled from MISO on the eight rising SCK edges of entry i reads back from word 0x20+2*i+1, bits 7:0.
- R4: A run sends the entries from the first index (word 0x50) through the last index (word 0x51), both inclusive, in ascending order, modulo 16. A run can send all 16 entries.
- R5: In command entry i, bit 0 picks the chip-select line: 0 drives spi_cs_n[0] low and 1 drives spi_cs_n[1] low. Bit 7 set keeps the select low into the next entry on the same line. Bit 7 clear releases the select after the byte, and the next entry asserts it again.
- R6: Writing control bit 0 = 1 starts a run. When the run ends, control bit 0 reads 0 and status bit 0 reads 1. Any write to the status word clears that bit.
- R7: If the last entry has bit 7 set, control bit 1 is set and lock bit 0 is 1, the select stays low after the run. The next run then continues without a new select edge. Writing lock 0 releases the select.
- R8: While control bit 0 reads 1, writes to the transmit file, the command file, both index registers, the control word and the divider are ignored.
- R9: Writing pin mode bit 0 = 1 hands the pins to the master only when boot_busy is 0. In boot mode a run cannot start, the select lines stay high and SCK stays low. pins_master mirrors the mode bit.
- R10: With divider value N (0 behaves as 1), each SCK half period lasts N clock cycles. The select goes low N cycles before the first rising edge and rises N cycles after the final falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| boot_busy | input | 1 | Boot-read engine busy indication |
| pins_master | output | 1 | 1 when this master owns the pins |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
Two events can fall in one clock: a register write and the end of a run. A write to the queue files, the indexes or the control word can arrive while the engine is still shifting. A write that clears the status word can meet the cycle in which the engine signals completion. The bench issues writes during a long run with a large divider and then reads back the old contents, which must be unchanged. After the run it checks that the completion flag and the cleared run bit appear together. It also confirms that no later status write is lost or taken as a new start.

// File: rtl/qmspi_pkg.sv
// Shared constants and types for the queued SPI master.
// Assumes QDEPTH is a power of two and that the register windows fit ADDR_W.
package qmspi_pkg;
    localparam int QDEPTH = 16;
    localparam int PW     = $clog2(QDEPTH);
    localparam int ADDR_W = 7;
    localparam int DIVW   = 8;

    localparam logic [ADDR_W-1:0] A_RX     = ADDR_W'(2 * QDEPTH);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(4 * QDEPTH);
    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(5 * QDEPTH);
    localparam logic [ADDR_W-1:0] A_END    = ADDR_W'(5 * QDEPTH + 1);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(5 * QDEPTH + 2);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(5 * QDEPTH + 3);
    localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(5 * QDEPTH + 4);
    localparam logic [ADDR_W-1:0] A_BAUD   = ADDR_W'(5 * QDEPTH + 5);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(5 * QDEPTH + 6);

    localparam int CMD_CONT_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_LEAD, ST_SHIFT, ST_TRAIL, ST_GAP
    } eng_st_t;
endpackage

// File: rtl/qmspi_halfclk.sv
// Half-period tick generator: pulses tick once every N cycles while en is high.
// Assumes div is held stable while en is high; a div of 0 acts as 1.
module qmspi_halfclk #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    // Effective terminal count.
    always_comb lim = (div == '0) ? DIVW'(1) : div;
    // Tick on the last cycle of each half period.
    always_comb tick = en && (cnt == lim - DIVW'(1));

    // Count cycles inside a half period, restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + DIVW'(1);
    end
endmodule

// File: rtl/qmspi_engine.sv
// Queue walker and byte shifter, SPI mode 0, MSB first.
// Assumes the register side keeps start/end pointers, tx and cmd entries
// stable while a run is active; tx_byte/cmd_* are indexed by ptr.
module qmspi_engine import qmspi_pkg::*; #(
    parameter int PW   = 4,
    parameter int NCS  = 2,
    localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PW-1:0]   start_ptr,
    input  logic [PW-1:0]   end_ptr,
    input  logic [7:0]      tx_byte,
    input  logic            cmd_cont,
    input  logic [SELW-1:0] cmd_sel,
    input  logic            hold_after,
    input  logic            lock,
    input  logic            tick,
    input  logic            miso,
    output logic [PW-1:0]   ptr,
    output logic            half_en,
    output logic            rx_we,
    output logic [7:0]      rx_byte,
    output logic            done,
    output logic            sck,
    output logic            mosi,
    output logic [NCS-1:0]  cs_n
);
    eng_st_t         st;
    logic [7:0]      sr;
    logic [7:0]      rsr;
    logic [2:0]      bitcnt;
    logic            cs_on;
    logic [SELW-1:0] cs_sel;
    logic            last;

    // Divider runs only in timed states.
    always_comb half_en = (st == ST_LEAD) || (st == ST_SHIFT) ||
                          (st == ST_TRAIL) || (st == ST_GAP);
    // Current entry is the final one of the run.
    always_comb last = (ptr == end_ptr);
    // Byte complete on the eighth falling tick.
    always_comb rx_we = (st == ST_SHIFT) && tick && sck && (bitcnt == 3'd7);
    always_comb rx_byte = rsr;
    always_comb mosi = sr[7];

    // Decode the active select line.
    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(cs_on && (cs_sel == SELW'(g)));
    end

    // Queue walk, select control and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; ptr <= '0; sr <= '0; rsr <= '0; bitcnt <= '0;
            sck <= 1'b0; cs_on <= 1'b0; cs_sel <= '0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (!lock) cs_on <= 1'b0;
                    if (start) begin
                        ptr <= start_ptr;
                        st  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    sr     <= tx_byte;
                    bitcnt <= '0;
                    if (cs_on && cs_sel == cmd_sel) st <= ST_SHIFT;
                    else begin
                        cs_sel <= cmd_sel;
                        cs_on  <= 1'b1;
                        st     <= ST_LEAD;
                    end
                end
                ST_LEAD: if (tick) begin
                    st  <= ST_SHIFT;
                    sck <= 1'b1;
                    rsr <= {rsr[6:0], miso};
                end
                ST_SHIFT: if (tick) begin
                    if (!sck) begin
                        sck <= 1'b1;
                        rsr <= {rsr[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitcnt != 3'd7) begin
                            bitcnt <= bitcnt + 3'd1;
                            sr     <= {sr[6:0], 1'b0};
                        end else if (!cmd_cont) st <= ST_TRAIL;
                        else if (!last) begin
                            ptr <= ptr + PW'(1);
                            st  <= ST_LOAD;
                        end else if (hold_after && lock) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else st <= ST_TRAIL;
                    end
                end
                ST_TRAIL: if (tick) begin
                    cs_on <= 1'b0;
                    if (last) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        ptr <= ptr + PW'(1);
                        st  <= ST_GAP;
                    end
                end
                ST_GAP: if (tick) st <= ST_LOAD;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // SCK may only be high inside an asserted select (R5).
    p_sck_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> cs_on);
    // A captured byte always belongs to a selected device (R3).
    p_rx_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> cs_on);
    // Completion follows the final queue entry (R4).
    p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ptr == end_ptr));
endmodule

// File: rtl/qmspi_ctrl.sv
// Queued SPI master top: word register port, queue files and pin ownership.
// Assumes single-cycle register writes and combinational reads; the boot-read
// engine sits outside and only exchanges the busy/ownership handshake.
module qmspi_ctrl import qmspi_pkg::*; #(
    parameter int NCS = 2,
    localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              boot_busy,
    output logic              pins_master,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs_n
);
    logic [7:0]      tx_mem   [QDEPTH];
    logic [7:0]      rx_mem   [QDEPTH];
    logic            cmd_cont [QDEPTH];
    logic [SELW-1:0] cmd_sel  [QDEPTH];
    logic [PW-1:0]   start_ptr, end_ptr;
    logic            spe, hold_after, spif, lock, master;
    logic [DIVW-1:0] baud;

    logic            is_tx, is_rx, is_cmd, start;
    logic [PW-1:0]   eng_ptr;
    logic            half_en, tick, rx_we, eng_done, eng_sck, eng_mosi;
    logic [7:0]      rx_byte;
    logic [NCS-1:0]  eng_cs_n;

    // Window decode of the register port.
    always_comb begin
        is_tx  = reg_addr < A_RX;
        is_rx  = (reg_addr >= A_RX) && (reg_addr < A_CMD);
        is_cmd = (reg_addr >= A_CMD) && (reg_addr < A_START);
    end
    // Run request accepted only when idle and owning the pins.
    always_comb start = reg_we && (reg_addr == A_CTRL) && reg_wdata[0] &&
                        !spe && master;

    qmspi_halfclk #(.DIVW(DIVW)) u_half (
        .clk(clk), .rst_n(rst_n), .en(half_en), .div(baud), .tick(tick)
    );

    qmspi_engine #(.PW(PW), .NCS(NCS)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_ptr(start_ptr), .end_ptr(end_ptr),
        .tx_byte(tx_mem[eng_ptr]), .cmd_cont(cmd_cont[eng_ptr]),
        .cmd_sel(cmd_sel[eng_ptr]), .hold_after(hold_after), .lock(lock),
        .tick(tick), .miso(spi_miso), .ptr(eng_ptr), .half_en(half_en),
        .rx_we(rx_we), .rx_byte(rx_byte), .done(eng_done),
        .sck(eng_sck), .mosi(eng_mosi), .cs_n(eng_cs_n)
    );

    // Register writes, completion and receive capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) begin
                tx_mem[i] <= '0; rx_mem[i] <= '0;
                cmd_cont[i] <= 1'b0; cmd_sel[i] <= '0;
            end
            start_ptr <= '0; end_ptr <= '0; spe <= 1'b0; hold_after <= 1'b0;
            spif <= 1'b0; lock <= 1'b0; master <= 1'b0; baud <= '0;
        end else begin
            if (rx_we) rx_mem[eng_ptr] <= rx_byte;
            if (reg_we && !spe) begin
                if (is_tx && !reg_addr[0]) tx_mem[reg_addr[PW:1]] <= reg_wdata[7:0];
                if (is_cmd) begin
                    cmd_cont[reg_addr[PW-1:0]] <= reg_wdata[CMD_CONT_BIT];
                    cmd_sel[reg_addr[PW-1:0]]  <= reg_wdata[SELW-1:0];
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    A_START:  if (!spe) start_ptr <= reg_wdata[PW-1:0];
                    A_END:    if (!spe) end_ptr <= reg_wdata[PW-1:0];
                    A_CTRL:   if (!spe) hold_after <= reg_wdata[1];
                    A_STATUS: spif <= 1'b0;
                    A_LOCK:   lock <= reg_wdata[0];
                    A_BAUD:   if (!spe) baud <= reg_wdata[DIVW-1:0];
                    A_MODE: begin
                        if (reg_wdata[0] && !boot_busy) master <= 1'b1;
                        else if (!reg_wdata[0] && !spe) master <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (start) spe <= 1'b1;
            if (eng_done) begin
                spe  <= 1'b0;
                spif <= 1'b1;
            end
        end
    end

    // Combinational register read-back.
    always_comb begin
        reg_rdata = '0;
        if (is_tx) begin
            if (!reg_addr[0]) reg_rdata[7:0] = tx_mem[reg_addr[PW:1]];
        end else if (is_rx) begin
            if (reg_addr[0]) reg_rdata[7:0] = rx_mem[reg_addr[PW:1]];
        end else if (is_cmd) begin
            reg_rdata[CMD_CONT_BIT] = cmd_cont[reg_addr[PW-1:0]];
            reg_rdata[SELW-1:0]     = cmd_sel[reg_addr[PW-1:0]];
        end else begin
            case (reg_addr)
                A_START:  reg_rdata[PW-1:0] = start_ptr;
                A_END:    reg_rdata[PW-1:0] = end_ptr;
                A_CTRL:   reg_rdata[1:0] = {hold_after, spe};
                A_STATUS: reg_rdata[0] = spif;
                A_LOCK:   reg_rdata[0] = lock;
                A_BAUD:   reg_rdata[DIVW-1:0] = baud;
                A_MODE:   reg_rdata[0] = master;
                default:  reg_rdata = '0;
            endcase
        end
    end

    // Pin ownership gating.
    always_comb begin
        pins_master = master;
        spi_sck     = master && eng_sck;
        spi_mosi    = master && eng_mosi;
        spi_cs_n    = master ? eng_cs_n : '1;
    end

    // A run is only ever active in master mode (R9).
    p_spe_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spe |-> master);
    // Ownership is only taken while the boot engine is idle (R9).
    p_master_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master) |-> $past(!boot_busy));
    // Completion sets the flag and drops the run bit together (R6).
    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (spif && !spe));
    // Queue indexes frozen during a run (R8).
    p_ptr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spe && $past(spe)) |-> ($stable(start_ptr) && $stable(end_ptr)));
endmodule

// File: tb/qmspi_ctrl_tb_top.sv
module qmspi_ctrl_tb_top;
    import qmspi_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        boot_busy = 1'b0;
    logic        pins_master;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [1:0]  spi_cs_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    qmspi_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .boot_busy(boot_busy),
        .pins_master(pins_master), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // ---------------- slave model ----------------
    function automatic logic [7:0] resp_f(int k);
        return 8'((k * 29 + 90) & 255);
    endfunction

    logic [7:0] mlog [512];
    int         slv_cnt = 0;
    int         slv_bits = 0;
    logic [7:0] slv_sh = '0;
    logic [7:0] slv_cur = 8'd90;
    int         falls = 0;
    int         falls1 = 0;
    wire        cs_any_n = &spi_cs_n;

    always @(posedge spi_sck) begin
        slv_sh = {slv_sh[6:0], spi_mosi};
        slv_bits = slv_bits + 1;
        if (slv_bits == 8) begin
            mlog[slv_cnt & 511] = slv_sh;
            slv_cnt = slv_cnt + 1;
            slv_bits = 0;
            slv_cur = resp_f(slv_cnt);
        end
    end
    always @(negedge spi_sck) spi_miso = slv_cur[7 - slv_bits];
    always @(negedge cs_any_n) spi_miso = slv_cur[7 - slv_bits];
    always @(negedge spi_cs_n[0]) falls = falls + 1;
    always @(negedge spi_cs_n[1]) begin falls = falls + 1; falls1 = falls1 + 1; end

    // ---------------- timing monitor (R10) ----------------
    int  m_lead = 0, m_hi = 0, m_trail = 0, t_cnt = 0, pulses = 0;
    bit  seen = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (cs_any_n === 1'b1) begin
            if (prev_cs === 1'b0) m_trail = t_cnt;
            seen = 0; t_cnt = 0; pulses = 0;
        end else if (cs_any_n === 1'b0) begin
            if (prev_cs === 1'b1) begin m_lead = 0; m_hi = 0; end
            if (spi_sck) begin
                seen = 1; t_cnt = 0;
                if (pulses == 0) m_hi = m_hi + 1;
            end else begin
                if (!seen) m_lead = m_lead + 1; else t_cnt = t_cnt + 1;
                if (prev_sck) pulses = pulses + 1;
            end
        end
        prev_sck = spi_sck; prev_cs = cs_any_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    task automatic wait_done(string tag);
        logic [31:0] v;
        int t = 0;
        v = '0;
        while (v[0] !== 1'b1 && t < 20000) begin rd(A_STATUS, v); t++; end
        chk({tag, " completion"}, v[0], 1'b1);
    endtask

    // Fill tx entry i and cmd entry i.
    task automatic load_entry(int i, logic [7:0] b, bit cont, bit sel);
        wr(7'(2 * i), {24'd0, b});
        wr(7'(A_CMD + 7'(i)), {24'd0, cont, 6'd0, sel});
    endtask

    task automatic run(int st, int n, bit hold);
        wr(A_STATUS, 32'd0);
        wr(A_START, 32'(st));
        wr(A_END, 32'((st + n - 1) % 16));
        wr(A_CTRL, {30'd0, hold, 1'b1});
    endtask

    logic [7:0] txe [16];
    bit         conte [16];
    bit         sele [16];

    // Full randomized run compared against bench expectations.
    task automatic rand_run(int idx);
        int n, st, base, exp_falls, bad_tx, bad_rx;
        logic [31:0] v;
        n  = 1 + int'($urandom % 16);
        st = int'($urandom % 16);
        for (int i = 0; i < 16; i++) begin
            txe[i] = 8'($urandom); conte[i] = 1'($urandom); sele[i] = 1'($urandom);
            load_entry(i, txe[i], conte[i], sele[i]);
        end
        exp_falls = 1;
        for (int k = 0; k < n - 1; k++) begin
            if (!conte[(st + k) % 16] || sele[(st + k) % 16] != sele[(st + k + 1) % 16])
                exp_falls++;
        end
        base = slv_cnt; falls = 0;
        run(st, n, 1'b0);
        wait_done("R6 random");
        repeat (4) @(negedge clk);
        bad_tx = 0; bad_rx = 0;
        for (int k = 0; k < n; k++) begin
            int p = (st + k) % 16;
            if (mlog[(base + k) & 511] !== txe[p]) bad_tx++;
            rd(7'(A_RX + 7'(2 * p + 1)), v);
            if (v[7:0] !== resp_f(base + k)) bad_rx++;
        end
        chk($sformatf("R4 random %0d byte count", idx), 32'(slv_cnt - base), 32'(n));
        chk($sformatf("R2 random %0d mosi mismatches", idx), 32'(bad_tx), 0);
        chk($sformatf("R3 random %0d rx mismatches", idx), 32'(bad_rx), 0);
        chk($sformatf("R5 random %0d select edges", idx), 32'(falls), 32'(exp_falls));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL all watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        int base;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_MODE, v);   chk("R1 mode", v, 0);
        rd(A_CTRL, v);   chk("R1 control", v, 0);
        rd(A_STATUS, v); chk("R1 status", v, 0);
        rd(A_LOCK, v);   chk("R1 lock", v, 0);
        rd(A_BAUD, v);   chk("R1 divider", v, 0);
        chk("R1 pins", {pins_master, spi_sck, spi_mosi, spi_cs_n}, 5'b00011);

        // R9 ownership handshake
        boot_busy = 1'b1;
        wr(A_MODE, 1);
        rd(A_MODE, v); chk("R9 refused while busy", v, 0);
        chk("R9 pins_master stays 0", pins_master, 0);
        load_entry(0, 8'hA5, 1'b0, 1'b0);
        wr(A_CTRL, 1);
        rd(A_CTRL, v); chk("R9 no run in boot mode", v, 0);
        repeat (10) @(negedge clk);
        chk("R9 pins idle in boot mode", {spi_sck, spi_cs_n}, 3'b011);
        boot_busy = 1'b0;
        wr(A_MODE, 1);
        rd(A_MODE, v); chk("R9 taken when idle", v, 1);
        chk("R9 pins_master", pins_master, 1);

        // R2/R3/R5/R6 directed 4-byte burst, select held between entries
        wr(A_BAUD, 2);
        load_entry(0, 8'h81, 1, 0); load_entry(1, 8'h3C, 1, 0);
        load_entry(2, 8'hFF, 1, 0); load_entry(3, 8'h00, 0, 0);
        base = slv_cnt; falls = 0;
        run(0, 4, 0);
        rd(A_CTRL, v); chk("R6 run bit during run", v[0], 1);
        wait_done("R6 directed");
        rd(A_CTRL, v); chk("R6 run bit cleared", v[0], 0);
        repeat (4) @(negedge clk);
        chk("R2 byte0", mlog[base], 8'h81);
        chk("R2 byte1", mlog[base + 1], 8'h3C);
        chk("R2 byte3", mlog[base + 3], 8'h00);
        rd(7'(A_RX + 7'd1), v); chk("R3 rx0", v, 32'(resp_f(base)));
        rd(7'(A_RX + 7'd7), v); chk("R3 rx3", v, 32'(resp_f(base + 3)));
        rd(A_RX, v);            chk("R3 even rx word", v, 0);
        chk("R5 one select edge", falls, 1);
        chk("R5 released after run", spi_cs_n, 2'b11);
        wr(A_STATUS, 0);
        rd(A_STATUS, v); chk("R6 status cleared", v, 0);

        // R5 no-continue on line 1
        load_entry(0, 8'h11, 0, 1); load_entry(1, 8'h22, 0, 1); load_entry(2, 8'h33, 0, 1);
        falls = 0; falls1 = 0;
        run(0, 3, 0);
        wait_done("R6 line1");
        repeat (4) @(negedge clk);
        chk("R5 three edges on line 1", falls1, 3);
        chk("R5 none on line 0", falls - falls1, 0);

        // R4 partial window and full queue
        for (int i = 0; i < 16; i++) load_entry(i, 8'(8'h40 + i), 1, 0);
        base = slv_cnt;
        run(5, 5, 0);
        wait_done("R6 window");
        repeat (4) @(negedge clk);
        chk("R4 window count", slv_cnt - base, 5);
        chk("R4 window first", mlog[base], 8'h45);
        chk("R4 window last", mlog[base + 4], 8'h49);
        base = slv_cnt;
        run(0, 16, 0);
        wait_done("R6 full");
        repeat (4) @(negedge clk);
        chk("R4 full count", slv_cnt - base, 16);
        chk("R4 full last", mlog[(base + 15) & 511], 8'h4F);

        // R7 hold across runs
        wr(A_LOCK, 1);
        load_entry(0, 8'h5A, 1, 0); load_entry(1, 8'hA5, 1, 0);
        run(0, 2, 1);
        wait_done("R6 hold");
        repeat (6) @(negedge clk);
        chk("R7 select held after run", spi_cs_n, 2'b10);
        falls = 0;
        load_entry(1, 8'hC3, 0, 0);
        run(0, 2, 1);
        wait_done("R6 hold second");
        repeat (6) @(negedge clk);
        chk("R7 no new select edge", falls, 0);
        chk("R7 released by last entry", spi_cs_n, 2'b11);
        load_entry(1, 8'hC3, 1, 0);
        run(0, 2, 1);
        wait_done("R6 hold third");
        repeat (4) @(negedge clk);
        chk("R7 held before unlock", spi_cs_n, 2'b10);
        wr(A_LOCK, 0);
        repeat (2) @(negedge clk);
        chk("R7 unlock releases", spi_cs_n, 2'b11);
        wr(A_CTRL, 0);

        // R8 writes ignored during a long run
        wr(A_BAUD, 20);
        for (int i = 0; i < 16; i++) load_entry(i, 8'(i * 3), 1, 0);
        run(0, 16, 0);
        wr(7'd0, 32'hEE);
        wr(A_START, 7);
        wr(7'(A_CMD), 32'h1);
        wr(A_BAUD, 5);
        rd(7'd0, v);     chk("R8 tx frozen", v, 0);
        rd(A_START, v);  chk("R8 start index frozen", v, 0);
        rd(7'(A_CMD), v); chk("R8 cmd frozen", v, 32'h80);
        rd(A_BAUD, v);   chk("R8 divider frozen", v, 20);
        wait_done("R6 long");
        rd(7'd0, v);     chk("R8 tx after run", v, 0);
        rd(A_CTRL, v);   chk("R6 run bit after long run", v[0], 0);

        // R10 timing with N = 3
        wr(A_BAUD, 3);
        load_entry(0, 8'h96, 0, 0);
        run(0, 1, 0);
        wait_done("R6 timing");
        repeat (4) @(negedge clk);
        chk("R10 lead cycles", m_lead, 3);
        chk("R10 high cycles", m_hi, 3);
        chk("R10 trail cycles", m_trail, 3);
        wr(A_BAUD, 0);
        run(0, 1, 0);
        wait_done("R6 zero divider");
        repeat (4) @(negedge clk);
        chk("R10 divider 0 as 1", m_hi, 1);

        // Randomized runs
        wr(A_BAUD, 1);
        for (int r = 0; r < 6; r++) rand_run(r);

        summary();
    end
endmodule